// File: doc/BRIEF.md
# AHB Burst Sequence Monitor

This block is a passive observer on the address phase of an AHB bus. It never drives the bus. On every clock edge where the bus is ready, it samples the transfer type, address, size and burst code. When a burst opens, it captures the opening beat and predicts the address of every following beat, including the wrap-around inside the aligned window used by wrapping bursts. It then compares each observed beat against that prediction.

Four sticky flags report protocol faults: a misaligned opening address, an address that differs from the prediction, an illegal transfer-type sequence, and a change of size or burst code inside a burst. The flags hold until a synchronous clear. A one-cycle completion pulse marks the acceptance of the last beat of every fixed-length burst. The monitor is placed beside a bus segment in simulation or in silicon debug logic, and its flags are collected by whatever supervises that segment.

Top module: `ahb_burst_monitor`

## Requirements
- R1: During and directly after reset, all four error flags and the completion pulse are low.
- R2: An opening beat (transfer type NONSEQ = 2'b10) whose address has any of its low `size` bits set raises `err_align` on the following cycle. The beat width is 2^size bytes.
- R3: Each SEQ beat (2'b11) is expected at the previous predicted address plus 2^size. In a burst with burst code INCR (3'b001), INCR4 (3'b011), INCR8 (3'b101) or INCR16 (3'b111), any other address raises `err_addr`.
- R4: For WRAP4 (3'b010), WRAP8 (3'b100) and WRAP16 (3'b110), the window is N*2^size bytes, where N is the beat count. Its base is the opening address rounded down to a multiple of that span. The predicted address stays inside the window, so WRAP8 with size 2 from 0x34 is predicted as 0x38, 0x3C, 0x20, 0x24, 0x28, 0x2C, 0x30.
- R5: A SEQ or BUSY (2'b01) beat while no burst is open raises `err_trans`. This includes a beat that follows the final beat of a fixed-length burst.
- R6: An IDLE (2'b00) or NONSEQ beat before the final beat of a fixed-length burst raises `err_trans`. It does not do so for an undefined-length INCR burst.
- R7: A SEQ beat whose size or burst code differs from the opening beat raises `err_ctrl`.
- R8: Cycles with `bus_ready` low are ignored, whatever values the bus carries.
- R9: A BUSY beat inside a burst neither advances the predicted address nor counts as a beat.
- R10: `burst_done` pulses for one cycle, on the cycle after the final beat of a fixed-length burst is accepted. A SINGLE burst (3'b000) completes on its opening beat. An INCR burst never produces the pulse.
- R11: The flags stay set until `err_clr` is sampled high. When a clear and a new fault occur in the same cycle, the flag for that fault ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_trans | input | 2 | Observed transfer type |
| bus_addr | input | AW | Observed address |
| bus_size | input | 3 | Observed transfer size (log2 bytes) |
| bus_burst | input | 3 | Observed burst code |
| bus_ready | input | 1 | Bus ready; beats are sampled only when high |
| err_clr | input | 1 | Synchronous clear of all error flags |
| err_align | output | 1 | Sticky misaligned-start flag |
| err_addr | output | 1 | Sticky address-mismatch flag |
| err_trans | output | 1 | Sticky transfer-type sequencing flag |
| err_ctrl | output | 1 | Sticky size/burst-change flag |
| burst_done | output | 1 | One-cycle pulse after the final beat of a fixed-length burst |

## Verification
Two functions can land in the same cycle. The first is a software clear of the flags, which can coincide with a newly detected fault. The second is the completion pulse of one burst, which can coincide with the opening beat of the next. The bench drives a misaligned opening beat with `err_clr` held high and expects `err_align` set afterwards. Back-to-back SINGLE bursts and bursts that start right after a final beat probe the second case, and each one must pulse `burst_done` without raising `err_trans`.

// File: rtl/mon_pkg.sv
// Package: shared encodings and burst-length decode for the burst monitor.
// Assumes standard AHB transfer-type and burst-code values.
package mon_pkg;
    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    localparam int CNT_W = 5;

    // Beat count of a burst code; 0 means undefined length.
    function automatic logic [CNT_W-1:0] burst_beats(input logic [2:0] code);
        case (code)
            3'b000:          burst_beats = 5'd1;
            3'b010, 3'b011:  burst_beats = 5'd4;
            3'b100, 3'b101:  burst_beats = 5'd8;
            3'b110, 3'b111:  burst_beats = 5'd16;
            default:         burst_beats = 5'd0;
        endcase
    endfunction

    // True for the wrapping burst codes.
    function automatic logic burst_wraps(input logic [2:0] code);
        burst_wraps = (code == 3'b010) || (code == 3'b100) || (code == 3'b110);
    endfunction
endpackage

// File: rtl/seq_addr_gen.sv
// Next-address predictor: given a beat address, size and burst code,
// returns the address of the following beat. Wrapping codes keep the
// result inside the span-aligned window. Purely combinational.
module seq_addr_gen
    import mon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    cur_size,
    input  logic [2:0]    cur_burst,
    output logic [AW-1:0] nxt_addr
);
    logic [AW-1:0] step;
    logic [AW-1:0] span_mask;

    // Compute step and wrap mask, then merge base bits with the advanced offset.
    always_comb begin
        step      = AW'(1) << cur_size;
        span_mask = (AW'(burst_beats(cur_burst)) << cur_size) - AW'(1);
        if (burst_wraps(cur_burst))
            nxt_addr = (cur_addr & ~span_mask) | ((cur_addr + step) & span_mask);
        else
            nxt_addr = cur_addr + step;
    end
endmodule

// File: rtl/burst_tracker.sv
// Burst tracker: follows open bursts on accepted beats, holds the predicted
// address and captured control, and produces per-cycle fault events plus
// a registered completion pulse. Assumes beats count only when ready is high.
module burst_tracker
    import mon_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_trans,
    input  logic [AW-1:0] bus_addr,
    input  logic [2:0]    bus_size,
    input  logic [2:0]    bus_burst,
    input  logic          bus_ready,
    output logic          ev_align,
    output logic          ev_addr,
    output logic          ev_trans,
    output logic          ev_ctrl,
    output logic          done_pulse
);
    logic             active;
    logic             undef_len;
    logic [CNT_W-1:0] left;
    logic [AW-1:0]    exp_addr;
    logic [AW-1:0]    start_addr;
    logic [2:0]       cap_size;
    logic [2:0]       cap_burst;

    logic [AW-1:0]    gen_cur;
    logic [2:0]       gen_size;
    logic [2:0]       gen_burst;
    logic [AW-1:0]    gen_nxt;
    logic [CNT_W-1:0] open_len;

    // Predictor input: bus values on an opening beat, captured state otherwise.
    always_comb begin
        if (bus_trans == TR_NSEQ) begin
            gen_cur   = bus_addr;
            gen_size  = bus_size;
            gen_burst = bus_burst;
        end else begin
            gen_cur   = exp_addr;
            gen_size  = cap_size;
            gen_burst = cap_burst;
        end
        open_len = burst_beats(bus_burst);
    end

    seq_addr_gen #(.AW(AW)) u_gen (
        .cur_addr  (gen_cur),
        .cur_size  (gen_size),
        .cur_burst (gen_burst),
        .nxt_addr  (gen_nxt)
    );

    // Fault events for the current accepted beat.
    always_comb begin
        ev_align = bus_ready && (bus_trans == TR_NSEQ) &&
                   (|(bus_addr & ((AW'(1) << bus_size) - AW'(1))));
        ev_addr  = bus_ready && (bus_trans == TR_SEQ) && active &&
                   (bus_addr != exp_addr);
        ev_ctrl  = bus_ready && (bus_trans == TR_SEQ) && active &&
                   ((bus_size != cap_size) || (bus_burst != cap_burst));
        ev_trans = bus_ready &&
                   ((((bus_trans == TR_SEQ) || (bus_trans == TR_BUSY)) && !active) ||
                    (((bus_trans == TR_IDLE) || (bus_trans == TR_NSEQ)) && active && !undef_len));
    end

    // Burst state update on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            undef_len  <= 1'b0;
            left       <= '0;
            exp_addr   <= '0;
            start_addr <= '0;
            cap_size   <= '0;
            cap_burst  <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (bus_ready) begin
                case (bus_trans)
                    TR_NSEQ: begin
                        start_addr <= bus_addr;
                        cap_size   <= bus_size;
                        cap_burst  <= bus_burst;
                        exp_addr   <= gen_nxt;
                        undef_len  <= (open_len == '0);
                        left       <= open_len - CNT_W'(1);
                        if (open_len == CNT_W'(1)) begin
                            active     <= 1'b0;
                            done_pulse <= 1'b1;
                        end else begin
                            active     <= 1'b1;
                        end
                    end
                    TR_SEQ: begin
                        if (active) begin
                            exp_addr <= gen_nxt;
                            if (!undef_len) begin
                                left <= left - CNT_W'(1);
                                if (left == CNT_W'(1)) begin
                                    active     <= 1'b0;
                                    done_pulse <= 1'b1;
                                end
                            end
                        end
                    end
                    TR_IDLE: active <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    logic [AW-1:0] win_mask;
    assign win_mask = (AW'(burst_beats(cap_burst)) << cap_size) - AW'(1);

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> $stable(exp_addr) && $stable(left) && $stable(active)); // R8
    AST_BUSY_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && (bus_trans == TR_BUSY) |=> $stable(exp_addr) && $stable(left)); // R9
    AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        active && burst_wraps(cap_burst) |-> ((exp_addr ^ start_addr) & ~win_mask) == '0); // R4
    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(bus_ready) && !active); // R10
endmodule

// File: rtl/err_flags.sv
// Sticky error register bank: each bit sets on its event and clears on a
// synchronous clear; a coincident event wins over the clear.
module err_flags #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NF-1:0] ev,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        // Hold, clear, or set one flag.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= (flags[i] && !clr) || ev[i];
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !clr |=> flags[i]); // R11
        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flags[i]); // R11
    end
endmodule

// File: rtl/ahb_burst_monitor.sv
// Top: passive AHB address-phase burst monitor. Joins the burst tracker
// with the sticky flag bank. Assumes it only observes, never drives.
module ahb_burst_monitor #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_trans,
    input  logic [AW-1:0] bus_addr,
    input  logic [2:0]    bus_size,
    input  logic [2:0]    bus_burst,
    input  logic          bus_ready,
    input  logic          err_clr,
    output logic          err_align,
    output logic          err_addr,
    output logic          err_trans,
    output logic          err_ctrl,
    output logic          burst_done
);
    localparam int NFLAG = 4;

    logic [NFLAG-1:0] ev;
    logic [NFLAG-1:0] flags;

    burst_tracker #(.AW(AW)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_trans  (bus_trans),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_burst  (bus_burst),
        .bus_ready  (bus_ready),
        .ev_align   (ev[0]),
        .ev_addr    (ev[1]),
        .ev_trans   (ev[2]),
        .ev_ctrl    (ev[3]),
        .done_pulse (burst_done)
    );

    err_flags #(.NF(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .ev    (ev),
        .flags (flags)
    );

    assign err_align = flags[0];
    assign err_addr  = flags[1];
    assign err_trans = flags[2];
    assign err_ctrl  = flags[3];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !burst_done && (flags == '0)); // R1
endmodule

// File: tb/ahb_burst_monitor_test.sv
`timescale 1ns/1ps
module ahb_burst_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tr = 2'b00;
    logic [31:0] ad = '0;
    logic [2:0]  sz = '0;
    logic [2:0]  bc = '0;
    logic        rdy = 1'b1;
    logic        clr = 1'b0;
    logic        e_al, e_ad, e_tr, e_ct, done;
    int checks = 0;
    int errors = 0;
    bit over = 0;

    always #2 clk = ~clk;

    ahb_burst_monitor #(.AW(32)) uut (
        .clk(clk), .rst_n(rst_n), .bus_trans(tr), .bus_addr(ad),
        .bus_size(sz), .bus_burst(bc), .bus_ready(rdy), .err_clr(clr),
        .err_align(e_al), .err_addr(e_ad), .err_trans(e_tr), .err_ctrl(e_ct),
        .burst_done(done)
    );

    function automatic int n_beats(int b);
        case (b)
            0: return 1;
            2, 3: return 4;
            4, 5: return 8;
            6, 7: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] pred(logic [31:0] a, int s, int b);
        int unsigned step = 1 << s;
        int unsigned span = n_beats(b) * step;
        logic [31:0] base;
        if (b == 2 || b == 4 || b == 6) begin
            base = a - (a % span);
            return base + ((a - base + step) % span);
        end
        return a + step;
    endfunction

    function automatic logic [3:0] flags();
        return {e_ct, e_tr, e_ad, e_al};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle; outputs reflecting it are readable on return.
    task automatic beat(logic [1:0] t, logic [31:0] a, int s, int b, bit r = 1, bit c = 0);
        tr = t; ad = a; sz = 3'(s); bc = 3'(b); rdy = r; clr = c;
        @(posedge clk);
        #1;
        clr = 1'b0;
    endtask

    task automatic clear_all();
        beat(2'b00, 0, 0, 0, 1, 1);
        chk(flags() == 4'h0, "R11", "clear", int'(flags()), 0);
    endtask

    // Full legal fixed-length burst with optional random stalls and BUSY.
    task automatic run_burst(logic [31:0] st, int s, int b, bit noisy, string req);
        logic [31:0] a = st;
        int n = n_beats(b);
        beat(2'b10, a, s, b);
        for (int k = 1; k < n; k++) begin
            chk(done == 1'b0, req, "done early", int'(done), 0);
            if (noisy && ($urandom % 4) == 0)
                beat(2'($urandom), $urandom, $urandom % 3, $urandom % 8, 0);
            if (noisy && ($urandom % 6) == 0)
                beat(2'b01, $urandom, s, b);
            a = pred(a, s, b);
            beat(2'b11, a, s, b);
        end
        chk(done == 1'b1, req, "done pulse", int'(done), 1);
        chk(flags() == 4'h0, req, "legal burst flags", int'(flags()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #1;
        chk(flags() == 4'h0 && done == 1'b0, "R1", "in reset", int'(flags()), 0);
        rst_n = 1'b1;
        beat(2'b00, 0, 0, 0);
        chk(flags() == 4'h0 && done == 1'b0, "R1", "after reset", int'(flags()), 0);

        // R4 wrap examples
        chk(pred(32'h3C, 2, 4) == 32'h20, "R4", "model wrap", int'(pred(32'h3C, 2, 4)), 32'h20);
        run_burst(32'h34, 2, 4, 0, "R4");
        run_burst(32'h04, 2, 4, 0, "R4");
        run_burst(32'h06, 1, 2, 0, "R4");
        // R3 incrementing
        run_burst(32'h100, 2, 5, 0, "R3");
        // R10 back-to-back singles
        run_burst(32'h40, 2, 0, 0, "R10");
        run_burst(32'h44, 2, 0, 0, "R10");

        // R9 BUSY inside wrap burst: 0x6,busy,0x0,0x2,0x4
        beat(2'b10, 32'h6, 1, 2);
        beat(2'b01, 32'h0, 1, 2);
        beat(2'b11, 32'h0, 1, 2);
        beat(2'b01, 32'h2, 1, 2);
        beat(2'b11, 32'h2, 1, 2);
        beat(2'b11, 32'h4, 1, 2);
        chk(done == 1'b1 && flags() == 4'h0, "R9", "busy not counted", int'(flags()), 0);

        // R8 stall with garbage
        beat(2'b10, 32'h200, 2, 3);
        beat(2'b00, 32'hDEAD, 1, 0, 0);
        beat(2'b10, 32'h3, 2, 7, 0);
        beat(2'b11, 32'h204, 2, 3);
        beat(2'b11, 32'h208, 2, 3);
        beat(2'b11, 32'h20C, 2, 3);
        chk(done == 1'b1 && flags() == 4'h0, "R8", "stall ignored", int'(flags()), 0);

        // R5 late beat after completion
        beat(2'b11, 32'h210, 2, 3);
        chk(e_tr == 1'b1, "R5", "seq after end", int'(e_tr), 1);
        // R11 sticky across idle
        beat(2'b00, 0, 0, 0);
        chk(e_tr == 1'b1, "R11", "sticky", int'(e_tr), 1);
        clear_all();

        // R2 misaligned start
        beat(2'b10, 32'h5, 2, 0);
        chk(flags() == 4'h1, "R2", "misaligned", int'(flags()), 1);
        clear_all();

        // R3 wrong address then R6 early idle
        beat(2'b10, 32'h100, 2, 3);
        beat(2'b11, 32'h108, 2, 3);
        chk(flags() == 4'h2, "R3", "addr mismatch", int'(flags()), 2);
        beat(2'b00, 0, 0, 0);
        chk(flags() == 4'h6, "R6", "early idle", int'(flags()), 6);
        clear_all();

        // R6 early NONSEQ opens a new burst
        beat(2'b10, 32'h80, 2, 4);
        beat(2'b11, 32'h84, 2, 4);
        beat(2'b10, 32'h300, 2, 0);
        chk(flags() == 4'h4 && done == 1'b1, "R6", "early nonseq", int'(flags()), 4);
        clear_all();

        // R7 size change
        beat(2'b10, 32'h400, 2, 3);
        beat(2'b11, 32'h404, 1, 3);
        chk(e_ct == 1'b1, "R7", "control change", int'(e_ct), 1);
        beat(2'b00, 0, 0, 0);
        clear_all();

        // R6/R10 undefined INCR: no error on idle, no done
        beat(2'b10, 32'h500, 2, 1);
        for (int k = 1; k < 5; k++) begin
            beat(2'b11, 32'h500 + 32'(4 * k), 2, 1);
            chk(done == 1'b0, "R10", "incr no done", int'(done), 0);
        end
        beat(2'b00, 0, 0, 0);
        chk(flags() == 4'h0 && done == 1'b0, "R6", "incr ends by idle", int'(flags()), 0);

        // R11 clear coincident with fault
        beat(2'b10, 32'h2, 2, 0, 1, 1);
        chk(e_al == 1'b1, "R11", "fault wins over clear", int'(e_al), 1);
        clear_all();

        // R5 busy with no open burst
        beat(2'b01, 32'h0, 2, 0);
        chk(e_tr == 1'b1, "R5", "busy idle bus", int'(e_tr), 1);
        clear_all();

        // Random legal bursts with stalls and BUSY
        for (int i = 0; i < 60; i++) begin
            int b;
            int s = $urandom % 3;
            logic [31:0] st;
            do b = $urandom % 8; while (b == 1);
            st = ($urandom & 32'hFFF) & ~((32'd1 << s) - 1);
            if (($urandom % 3) == 0) beat(2'b00, 0, 0, 0);
            run_burst(st, s, b, 1, (b == 2 || b == 4 || b == 6) ? "R4" : "R3");
        end

        over = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule